// File: doc/BRIEF.md
# One-Shot Countdown Timer with Timeout Request

This block is a single-register, one-shot countdown timer for a USB device controller's system-control space. Software writes one 32-bit word. The top bit arms the timer, and the low 27 bits give the number of device-clock ticks to wait. The timer advances only on cycles where the `tick` input is high. The integrator drives `tick` at the 60 MHz device-clock rate, as a clock enable in the host clock domain.

When the programmed number of ticks has elapsed, the timer does two things in the same cycle. It clears its whole register to zero, and it raises a one-cycle timeout request toward the interrupt aggregator. The aggregator latches that request as a sticky timeout source. Software can therefore tell that the timer has fired by reading back zero.

A write with the top bit clear stops a countdown in progress. A new armed write restarts the countdown from its own count.

Top module: `otg_oneshot_timer`

## Requirements
- R1: After synchronous reset, `rd_data` reads 0 and `timeout_pulse` is low.
- R2: A write stores all 32 bits of `wr_data`, and `rd_data` shows them from the cycle after the write until the next write or expiry.
- R3: An armed write (bit 31 = 1) with count N ≥ 1 in bits 26:0 raises `timeout_pulse` in the cycle after the N-th `tick` that follows the write.
- R4: An armed write with count 0 expires on the first `tick` after the write, exactly as a count of 1 does.
- R5: In the cycle that `timeout_pulse` is high, `rd_data` reads 0. The whole register, enable bit included, has been cleared.
- R6: `timeout_pulse` is high for exactly one cycle per expiry, and it does not repeat until the timer is armed again.
- R7: A write with bit 31 = 0 cancels any countdown in progress, and no timeout follows it.
- R8: An armed write during a countdown discards the remaining count and restarts from the new count.
- R9: A `tick` in the same cycle as a write is not counted, and a write in the cycle that would expire prevents that expiry.
- R10: The count advances only on cycles with `tick` high. Gaps between ticks delay expiry without changing the number of ticks needed.
- R11: Bits 30:27 are stored and read back, but they have no effect on the countdown length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for the timer register |
| wr_data | input | 32 | Write value: bit 31 enable, bits 26:0 tick count |
| tick | input | 1 | One-cycle device-clock tick enable |
| rd_data | output | 32 | Current register value |
| timeout_pulse | output | 1 | One-cycle timeout request to the interrupt aggregator |

## Verification
The countdown is driven with ticks on every cycle and with ticks spaced three cycles apart. A dependence on cycles rather than ticks shows up only under the spaced pattern. Counts of 0, 1 and larger values separate the zero-count rule from an off-by-one in the terminal compare. Cancelling and re-arming mid-count show whether the old count leaks into the new one. A write landing on a tick cycle exposes which of the two has priority. Setting bits 30:27 checks that the count field is masked to its 27 bits.

// File: rtl/otgt_pkg.sv
// Package: shared widths and the counter state type for the one-shot timer.
// Assumes a 32-bit register with the enable bit at the top.
package otgt_pkg;
    localparam int unsigned DEF_REG_W  = 32;
    localparam int unsigned DEF_CNT_W  = 27;
    localparam int unsigned DEF_EN_BIT = 31;

    typedef enum logic {
        CD_IDLE = 1'b0,
        CD_RUN  = 1'b1
    } cd_state_e;
endpackage

// File: rtl/otgt_value_reg.sv
// Module: software-visible timer register.
// Loads the written word on a write strobe and clears to zero on expiry.
// Assumes a write and an expiry never coincide (the counter blocks expiry on writes).
module otgt_value_reg #(
    parameter int unsigned REG_W = otgt_pkg::DEF_REG_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [REG_W-1:0] load_val,
    input  logic             expire,
    output logic [REG_W-1:0] value
);
    logic [REG_W-1:0] value_q;

    // Hold the last written word, or zero once the timer has fired.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            value_q <= '0;
        end else if (load) begin
            value_q <= load_val;
        end else if (expire) begin
            value_q <= '0;
        end
    end

    assign value = value_q;
endmodule

// File: rtl/otgt_downcount.sv
// Module: tick-driven down counter with arm/cancel control.
// A load arms (load_en=1) or cancels (load_en=0) and always has priority over a tick.
// Expiry is flagged combinationally on the tick that consumes the last count;
// a count of 0 is treated like a count of 1.
module otgt_downcount #(
    parameter int unsigned CNT_W = otgt_pkg::DEF_CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             load_en,
    input  logic [CNT_W-1:0] load_cnt,
    input  logic             tick,
    output logic             expire
);
    import otgt_pkg::*;

    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(1);

    cd_state_e        state_q;
    logic [CNT_W-1:0] cnt_q;
    logic             at_end;

    // Last tick is reached when one or fewer ticks remain.
    assign at_end = (cnt_q <= LAST_CNT);
    // Expiry: running, ticking, not overridden by a write, and at the end.
    assign expire = (state_q == CD_RUN) && tick && !load && at_end;

    // Track armed state and remaining ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CD_IDLE;
            cnt_q   <= '0;
        end else if (load) begin
            state_q <= load_en ? CD_RUN : CD_IDLE;
            cnt_q   <= load_cnt;
        end else if (expire) begin
            state_q <= CD_IDLE;
        end else if (state_q == CD_RUN && tick) begin
            cnt_q <= cnt_q - LAST_CNT;
        end
    end
endmodule

// File: rtl/otgt_pulse.sv
// Module: registers the expiry strobe into a one-cycle request output.
// Assumes the input is high for at most one cycle per expiry.
module otgt_pulse (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    output logic pulse
);
    logic pulse_q;

    // Register the strobe so the request aligns with the cleared register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pulse_q <= 1'b0;
        end else begin
            pulse_q <= fire;
        end
    end

    assign pulse = pulse_q;
endmodule

// File: rtl/otg_oneshot_timer.sv
// Module: one-shot countdown timer with timeout request.
// One register: bit EN_BIT arms, bits CNT_W-1:0 give the tick count.
// Counts only on 'tick' cycles; on expiry clears the register and pulses
// timeout_pulse for one cycle. Assumes 'tick' is a single-cycle enable
// already in the clk domain.
module otg_oneshot_timer #(
    parameter int unsigned REG_W  = otgt_pkg::DEF_REG_W,
    parameter int unsigned CNT_W  = otgt_pkg::DEF_CNT_W,
    parameter int unsigned EN_BIT = otgt_pkg::DEF_EN_BIT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             tick,
    output logic [REG_W-1:0] rd_data,
    output logic             timeout_pulse
);
    logic expire_now;

    otgt_value_reg #(.REG_W(REG_W)) u_reg (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (wr_en),
        .load_val (wr_data),
        .expire   (expire_now),
        .value    (rd_data)
    );

    otgt_downcount #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (wr_en),
        .load_en  (wr_data[EN_BIT]),
        .load_cnt (wr_data[CNT_W-1:0]),
        .tick     (tick),
        .expire   (expire_now)
    );

    otgt_pulse u_pls (
        .clk   (clk),
        .rst_n (rst_n),
        .fire  (expire_now),
        .pulse (timeout_pulse)
    );
endmodule

// File: rtl/otgt_checker.sv
// Module: property checker for the one-shot timer, bound to the top module.
// Observes ports only.
module otgt_checker #(
    parameter int unsigned REG_W  = otgt_pkg::DEF_REG_W,
    parameter int unsigned EN_BIT = otgt_pkg::DEF_EN_BIT
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [REG_W-1:0] wr_data,
    input logic             tick,
    input logic [REG_W-1:0] rd_data,
    input logic             timeout_pulse
);
    p_reset_idle_r1: assert property (@(posedge clk)
        !rst_n |=> (rd_data == '0 && !timeout_pulse));

    p_write_visible_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (rd_data == $past(wr_data)));

    p_needs_tick_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout_pulse) |-> ($past(tick) && !$past(wr_en)));

    p_cleared_on_fire_r5: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_pulse |-> (rd_data == '0));

    p_single_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_pulse |=> !timeout_pulse);

    p_cancel_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_data[EN_BIT]) |=> !timeout_pulse);
endmodule

bind otg_oneshot_timer otgt_checker #(.REG_W(REG_W), .EN_BIT(EN_BIT)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_en         (wr_en),
    .wr_data       (wr_data),
    .tick          (tick),
    .rd_data       (rd_data),
    .timeout_pulse (timeout_pulse)
);

// File: tb/sim_otg_oneshot_timer.sv
`timescale 1ns/100ps
module sim_otg_oneshot_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        tick = 1'b0;
    logic [31:0] rd_data;
    logic        timeout_pulse;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 0;
    string cur_req = "R1";

    // Reference model state
    logic [31:0] m_reg = '0;
    bit          m_armed = 0;
    longint      m_left = 0;
    bit          m_pulse = 0;

    always #2.5 clk = ~clk;

    otg_oneshot_timer u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .tick(tick), .rd_data(rd_data), .timeout_pulse(timeout_pulse)
    );

    // Behavioural reference: what the register and request should be after each edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_reg = '0; m_armed = 0; m_left = 0; m_pulse = 0;
        end else begin
            m_pulse = 0;
            if (wr_en) begin
                m_reg   = wr_data;
                m_armed = wr_data[31];
                m_left  = wr_data & 32'h07FF_FFFF;
            end else if (tick && m_armed) begin
                m_left = m_left - 1;
                if (m_left <= 0) begin
                    m_armed = 0; m_reg = '0; m_pulse = 1;
                end
            end
        end
    end

    task automatic check(input string req, input bit ok, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drive one cycle's inputs (called at negedge), then compare at the next negedge.
    task automatic step(input bit w, input logic [31:0] d, input bit t);
        wr_en = w; wr_data = d; tick = t;
        @(negedge clk);
        check({cur_req, " rd_data"}, rd_data == m_reg, rd_data, m_reg);
        check({cur_req, " pulse"}, timeout_pulse == m_pulse, timeout_pulse, m_pulse);
    endtask

    // Arm, then tick every 'period' cycles; count ticks until the request shows up.
    task automatic arm_and_count(input logic [31:0] val, input int period,
                                 input int exp_ticks, input string req);
        int ticks = 0;
        bit seen = 0;
        cur_req = req;
        step(1, val, 0);
        for (int c = 0; c < 400 && !seen; c++) begin
            bit t = ((c % period) == period - 1);
            step(0, '0, t);
            if (t) ticks++;
            if (timeout_pulse) begin
                seen = 1;
                check({req, " cleared"}, rd_data == 0, rd_data, 0);
            end
        end
        check({req, " ticks to expiry"}, seen && ticks == exp_ticks, ticks, exp_ticks);
        step(0, '0, 1);
        check({req, " single pulse R6"}, !timeout_pulse, timeout_pulse, 0);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        n_fails++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        @(negedge clk);
        // R1 reset state
        cur_req = "R1";
        step(0, '0, 1);
        step(0, '0, 0);
        check("R1 reset rd", rd_data == 0, rd_data, 0);
        rst_n = 1'b1;
        step(0, '0, 0);

        // R2 plain write, R7 disabled write never fires
        cur_req = "R2";
        step(1, 32'h0000_1234, 0);
        check("R2 readback", rd_data == 32'h0000_1234, rd_data, 32'h1234);
        cur_req = "R7";
        for (int i = 0; i < 10; i++) step(0, '0, 1);
        check("R7 disabled no fire", rd_data == 32'h0000_1234, rd_data, 32'h1234);

        // R3/R5/R6 tick every cycle
        arm_and_count(32'h8000_0005, 1, 5, "R3");
        arm_and_count(32'h8000_0001, 1, 1, "R3");
        // R10 spaced ticks
        arm_and_count(32'h8000_0004, 3, 4, "R10");
        // R4 zero count
        arm_and_count(32'h8000_0000, 1, 1, "R4");
        arm_and_count(32'h8000_0000, 4, 1, "R4");
        // R11 upper bits ignored for length but stored
        cur_req = "R11";
        step(1, 32'hF800_0003, 0);
        check("R11 stored", rd_data == 32'hF800_0003, rd_data, 32'hF800_0003);
        arm_and_count(32'hF800_0003, 1, 3, "R11");

        // R7 cancel mid-count
        cur_req = "R7";
        step(1, 32'h8000_000A, 0);
        for (int i = 0; i < 3; i++) step(0, '0, 1);
        step(1, 32'h0000_000A, 1);
        for (int i = 0; i < 20; i++) step(0, '0, 1);
        check("R7 cancelled value kept", rd_data == 32'h0000_000A, rd_data, 32'hA);

        // R8 restart mid-count: 4 ticks of 8, then re-arm for 3
        cur_req = "R8";
        step(1, 32'h8000_0008, 0);
        for (int i = 0; i < 4; i++) step(0, '0, 1);
        arm_and_count(32'h8000_0003, 1, 3, "R8");

        // R9 write on a tick cycle: that tick not counted
        cur_req = "R9";
        step(1, 32'h8000_0002, 1);
        step(0, '0, 1);
        check("R9 not yet", !timeout_pulse, timeout_pulse, 0);
        step(0, '0, 1);
        check("R9 fires after two later ticks", timeout_pulse == 1, timeout_pulse, 1);
        // R9 write on the would-be expiry tick blocks it
        step(1, 32'h8000_0001, 0);
        step(1, 32'h0000_0055, 1);
        check("R9 expiry blocked", !timeout_pulse && rd_data == 32'h55, rd_data, 32'h55);
        for (int i = 0; i < 5; i++) step(0, '0, 1);

        finish_run();
    end
endmodule